// File: doc/BRIEF.md
# DMA Request Sequencer

This block sits in front of a DMA transfer engine and decides when the engine may move the next unit (one byte or word) and whether the channel keeps the bus between units. A request comes from an active-low external pin or from software. The pin can work in one of two ways. In edge mode each falling edge asks for one unit. In level mode a low pin keeps asking for units one after another. A software start needs no pin at all. It runs either in cycle-steal fashion, where the bus is given back after every unit, or in burst fashion, where the bus is kept until the last unit.

Software writes a mode and a nonzero unit count and pulses a start strobe. The sequencer then raises a unit request, which doubles as the request to the bus arbiter, and waits for the engine's unit-done pulse. Each unit-done lowers the count. When the count reaches zero the sequencer pulses an end flag for one clock and drops the channel enable. The pin passes through a synchronizer before any edge or level decision is made.

Top module: `dma_req_seq`

## Requirements
- R1: After reset, unit_req_o, bus_req_o, enable_o and xfer_end_o are low and count_o is zero.
- R2: A start_i pulse is accepted only while enable_o is low and count_i is nonzero. It loads count_o, sets enable_o and captures cfg_mode_i, where 0 = edge, 1 = level, 2 = auto cycle-steal and 3 = auto burst. A start at any other time has no effect.
- R3: The request pin is synchronized. When the channel is enabled and idle, a pin change made between clock edges raises unit_req_o after the third following rising edge.
- R4: In edge mode, each falling edge of the pin that reaches the sequencer while no unit is outstanding produces exactly one unit request.
- R5: In edge mode, a falling edge that occurs while a unit is outstanding is dropped and produces no extra unit.
- R6: In level mode, while the synchronized pin is low, units are requested back to back, with unit_req_o and bus_req_o low for exactly one clock between units.
- R7: In level mode, when the pin returns high, the unit in progress completes, no new unit is requested, and enable_o and count_o are kept for a later resume.
- R8: In auto cycle-steal mode, units run without any pin activity, and bus_req_o is low for exactly one clock after each unit-done that is not the last.
- R9: In auto burst mode, bus_req_o stays high continuously from the first unit until the unit-done of the last unit.
- R10: Each accepted unit-done lowers count_o by one. On the unit-done that brings the count to zero, xfer_end_o pulses for one clock, and enable_o, unit_req_o and bus_req_o go low.
- R11: A unit_done_i pulse while unit_req_o is low has no effect on count_o or enable_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 2 | Request mode, captured on an accepted start |
| start_i | input | 1 | Software start strobe |
| count_i | input | CNT_W | Unit count loaded on an accepted start |
| dreq_ni | input | 1 | External request pin, active low, asynchronous |
| unit_done_i | input | 1 | Engine reports that one unit has completed |
| unit_req_o | output | 1 | Request to the engine for one unit |
| bus_req_o | output | 1 | Bus request to the arbiter |
| enable_o | output | 1 | Channel enabled |
| count_o | output | CNT_W | Units remaining |
| xfer_end_o | output | 1 | One-clock pulse when the last unit completes |

## Verification
The bench builds the block with CNT_W = 8 and SYNC_STAGES = 2. The narrow count lets a burst run of the full 255 units finish in a few hundred clocks, so the count limit can be checked against continuous bus hold. The two-stage synchronizer fixes the pin-to-request latency at three edges, which a cycle model in the bench follows exactly. With that model, random pin waveforms, random engine latency and stray unit-done pulses can be compared on every clock in all four modes.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    MODE_EDGE  = 2'd0,
    MODE_LEVEL = 2'd1,
    MODE_STEAL = 2'd2,
    MODE_BURST = 2'd3
  } req_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic lvl_low_o,
  output logic fall_o
);
  localparam int SH_W = STAGES + 1;

  // sh[STAGES-1] is the synchronized pin, sh[STAGES] its previous value
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[SH_W-2:0], pin_ni};
  end

  assign lvl_low_o = ~sh_q[STAGES-1];
  assign fall_o    = sh_q[STAGES] & ~sh_q[STAGES-1];

  p_fall_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dma_req_count.sv
module dma_req_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q == ONE);

  p_count_dec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> (count_o == $past(count_o) - ONE));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_req_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_mode_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dreq_ni,
  input  logic             unit_done_i,
  output logic             unit_req_o,
  output logic             bus_req_o,
  output logic             enable_o,
  output logic [CNT_W-1:0] count_o,
  output logic             xfer_end_o
);
  seq_state_e state_q;
  req_mode_e  mode_q;
  logic       enable_q, end_q;
  logic       lvl_low, fall, last, fire, done_ok, accept;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_ni   (dreq_ni),
    .lvl_low_o(lvl_low),
    .fall_o   (fall)
  );

  assign done_ok = (state_q == ST_XFER) && unit_done_i;
  assign accept  = start_i && !enable_q && (count_i != '0);

  dma_req_count #(.CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(count_i),
    .dec_i     (done_ok),
    .count_o   (count_o),
    .last_o    (last)
  );

  always_comb begin
    unique case (mode_q)
      MODE_EDGE:  fire = enable_q && fall;
      MODE_LEVEL: fire = enable_q && lvl_low;
      default:    fire = enable_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_EDGE;
      enable_q <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      end_q <= done_ok && last;
      if (accept) begin
        enable_q <= 1'b1;
        mode_q   <= req_mode_e'(cfg_mode_i);
      end else if (done_ok && last) begin
        enable_q <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: if (fire) state_q <= ST_XFER;
        ST_XFER: if (done_ok && (last || mode_q != MODE_BURST)) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // bus stays requested for as long as a unit (or a burst of units) is open
  assign unit_req_o = (state_q == ST_XFER);
  assign bus_req_o  = (state_q == ST_XFER);
  assign enable_o   = enable_q;
  assign xfer_end_o = end_q;

  p_req_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_req_o |-> enable_o);

  p_end_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_o |-> (!enable_o && !bus_req_o && count_o == '0));

  p_start_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && enable_o && !unit_done_i) |=> (enable_o && $stable(count_o)));

  p_edge_needs_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(unit_req_o) && mode_q == MODE_EDGE) |-> $past(fall));

  p_steal_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && unit_done_i && mode_q != MODE_BURST) |=> !bus_req_o);

  p_burst_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && unit_done_i && mode_q == MODE_BURST && count_o > CNT_W'(1)) |=> bus_req_o);

  p_level_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unit_req_o && mode_q == MODE_LEVEL && !lvl_low) |=> !unit_req_o);
endmodule

// File: tb/dma_req_seq_tb_top.sv
module dma_req_seq_tb_top;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_mode_i = 2'd0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic             dreq_n = 1'b1;
  logic             unit_done_i = 1'b0;
  logic             unit_req_o, bus_req_o, enable_o, xfer_end_o;
  logic [CNT_W-1:0] count_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit chk_on = 0, eng_on = 0, stray = 0, done_flag = 0;
  int lat = 0;

  always #5 clk = ~clk;

  dma_req_seq #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg_mode_i), .start_i(start_i),
    .count_i(count_i), .dreq_ni(dreq_n), .unit_done_i(unit_done_i),
    .unit_req_o(unit_req_o), .bus_req_o(bus_req_o), .enable_o(enable_o),
    .count_o(count_o), .xfer_end_o(xfer_end_o)
  );

  // cycle model built from the requirements
  bit m_p1, m_p2, m_p3, m_busy, m_en, m_end;
  int m_cnt, m_mode;

  function automatic string tag_of(int md);
    case (md)
      0: return "R4";
      1: return "R6";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic bit fire_of(int md, bit fall, bit low);
    if (md == 0) return fall;
    if (md == 1) return low;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p1 = 1; m_p2 = 1; m_p3 = 1; m_busy = 0; m_en = 0; m_end = 0; m_cnt = 0; m_mode = 0;
    end else begin
      bit n_busy, n_en, n_end;
      int n_cnt;
      n_busy = m_busy; n_en = m_en; n_cnt = m_cnt; n_end = 0;
      if (!m_busy) begin
        if (m_en && fire_of(m_mode, m_p3 & ~m_p2, ~m_p2)) n_busy = 1;
      end else if (unit_done_i) begin
        n_cnt = m_cnt - 1;
        if (m_cnt == 1) begin n_busy = 0; n_en = 0; n_end = 1; end
        else if (m_mode != 3) n_busy = 0;
      end
      if (start_i && !m_en && count_i != 0) begin
        n_en = 1; n_cnt = int'(count_i); m_mode = int'(cfg_mode_i);
      end
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = dreq_n;
      m_busy = n_busy; m_en = n_en; m_cnt = n_cnt; m_end = n_end;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // compare against the model and emulate the engine, away from the rising edge
  always @(negedge clk) begin
    bit prev;
    if (rst_n && chk_on) begin
      check(tag_of(m_mode), int'(unit_req_o), int'(m_busy), "unit_req_o");
      check(tag_of(m_mode), int'(bus_req_o), int'(m_busy), "bus_req_o");
      check("R2", int'(enable_o), int'(m_en), "enable_o");
      check("R10", int'(count_o), m_cnt, "count_o");
      check("R10", int'(xfer_end_o), int'(m_end), "xfer_end_o");
    end
    prev = unit_done_i;
    unit_done_i = 1'b0;
    if (stray && !unit_req_o) unit_done_i = 1'b1;
    else if (eng_on && unit_req_o && !prev) begin
      if (lat == 0) begin unit_done_i = 1'b1; lat = $urandom % 3; end
      else lat--;
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      report();
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(int md, int cnt);
    @(negedge clk);
    cfg_mode_i = 2'(md); count_i = CNT_W'(cnt); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end(int limit);
    for (int i = 0; i < limit && enable_o; i++) @(negedge clk);
  endtask

  initial begin
    int seed, c0;
    seed = $urandom(32'h5eed_1234);
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(unit_req_o), 0, "unit_req_o");
    check("R1", int'(bus_req_o), 0, "bus_req_o");
    check("R1", int'(enable_o), 0, "enable_o");
    check("R1", int'(count_o), 0, "count_o");
    check("R1", int'(xfer_end_o), 0, "xfer_end_o");
    chk_on = 1;

    // R2: zero count start ignored
    do_start(2, 0);
    cycles(2);
    check("R2", int'(enable_o), 0, "enable after zero-count start");

    // R3: edge mode latency, engine held off
    do_start(0, 2);
    cycles(4);
    dreq_n = 1'b0;
    @(negedge clk); check("R3", int'(unit_req_o), 0, "req after edge 1");
    @(negedge clk); check("R3", int'(unit_req_o), 0, "req after edge 2");
    @(negedge clk); check("R3", int'(unit_req_o), 1, "req after edge 3");
    // R5: fall during an outstanding unit is dropped
    dreq_n = 1'b1; cycles(4); dreq_n = 1'b0; cycles(6);
    eng_on = 1; cycles(10);
    check("R5", int'(count_o), 1, "count after dropped edge");
    // R11: stray done while idle
    eng_on = 0; stray = 1; cycles(3); stray = 0; cycles(2);
    check("R11", int'(count_o), 1, "count after stray done");
    check("R11", int'(enable_o), 1, "enable after stray done");
    // R2: start while enabled ignored
    do_start(3, 9);
    check("R2", int'(count_o), 1, "count after start while enabled");
    // finish with one clean edge
    eng_on = 1;
    dreq_n = 1'b1; cycles(4); dreq_n = 1'b0; wait_end(40);
    check("R10", int'(enable_o), 0, "enable after last edge unit");
    dreq_n = 1'b1; cycles(4);

    // R7: level stop and resume
    do_start(1, 30);
    dreq_n = 1'b0; cycles(12);
    dreq_n = 1'b1; cycles(12);
    c0 = int'(count_o);
    check("R7", int'(unit_req_o), 0, "req after pin high");
    check("R7", int'(enable_o), 1, "enable kept");
    cycles(6);
    check("R7", int'(count_o), c0, "count frozen while pin high");
    dreq_n = 1'b0; wait_end(400);
    check("R6", int'(enable_o), 0, "level run completes");
    dreq_n = 1'b1; cycles(4);

    // R9: full-scale burst
    do_start(3, 255);
    wait_end(2000);
    check("R9", int'(count_o), 0, "burst count drained");

    // random mixes across all modes
    for (int it = 0; it < 60; it++) begin
      int md;
      md = $urandom % 4;
      do_start(md, 1 + $urandom % 12);
      for (int k = 0; k < 3000 && enable_o; k++) begin
        dreq_n = ($urandom % 3 == 0) ? ~dreq_n : dreq_n;
        stray = ($urandom % 9 == 0);
        @(negedge clk);
      end
      stray = 0;
      dreq_n = 1'b1; cycles(5);
    end

    cycles(4);
    done_flag = 1;
    report();
  end
endmodule